// File: doc/BRIEF.md
# Test Pattern Generator for a Pixel Output Path

This block sits at the end of a two-channel pixel data path, just before the 12-bit output register. When test mode is off, each pixel word passes straight through. When test mode is on, the block drops the sensor data and sends a synthetic pattern instead, so the downstream capture logic can be checked without a working sensor. There are two patterns. The first is a stripe that alternates between the programmed black level plus 128 LSB and the plain black level. The second is a gradation ramp that starts at 1 and climbs by a programmable step.

A pixel strobe marks each pixel, and a line-start pulse marks the start of each line. The enable, the pattern select, the 2-bit interval field and the 8-bit black-level code are sampled only at line start. A line start that arrives in the same cycle as a pixel strobe makes that pixel the first pixel of the new line. The core is a four-state machine:

- PASS: test mode off, data passes through.
- HI: stripe at the high level.
- LO: stripe at the black level.
- RAMP: gradation ramp.

Its transitions are:

- LINE_RESTART: from any state at line start, to PASS, HI or RAMP depending on the sampled enable and select.
- BAND_FLIP_DOWN: HI to LO on the last pixel of a band.
- BAND_FLIP_UP: LO to HI on the last pixel of a band.
- HOLD: no change otherwise.

Top module: `tpat_gen`

## Requirements
- R1: After reset, out_vld is 0 and out_code is 0. Until the first line start, pixels pass through unchanged even if tm_en is already 1.
- R2: tm_en, pat_sel, pat_ivl and blk_code are sampled only in a cycle with line_start = 1. Changing them in the middle of a line has no effect on that line.
- R3: Each pix_stb in cycle n gives out_vld = 1 with a new out_code after the clock edge that ends cycle n. With no strobe, out_vld is 0 and out_code holds its value.
- R4: A line started with tm_en = 0 passes pix_in to out_code.
- R5: A line started with tm_en = 1 and pat_sel = 1 produces a stripe:
  - The first W pixels equal 2·blk_code + 128, saturated at 4095.
  - The next W pixels equal 2·blk_code.
  - The two levels keep alternating every W pixels.
  - W = 8, 16, 32 or 64 for pat_ivl = 0, 1, 2 or 3.
- R6: A line started with tm_en = 1 and pat_sel = 0 produces a ramp. The first pixel is 1, and each later pixel adds S = 2, 4, 8 or 16 for pat_ivl = 0, 1, 2 or 3.
- R7: The ramp may reach 4095 exactly (S = 2 does so). When the next value would exceed 4095, the ramp restarts at 1.
- R8: A line start in the middle of a line restarts the stripe at the high level with a fresh band, or restarts the ramp at 1. This holds whether or not a pixel strobe arrives in the same cycle.
- R9: In test mode, pix_in has no effect on out_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_stb | input | 1 | One pixel in this cycle |
| line_start | input | 1 | First cycle of a line; samples settings |
| tm_en | input | 1 | Test mode enable |
| pat_sel | input | 1 | 0 = gradation ramp, 1 = stripe |
| pat_ivl | input | 2 | Stripe width / ramp step selector |
| blk_code | input | 8 | Black level code, level = 2 × code |
| pix_in | input | 12 | Sensor pixel word |
| out_code | output | 12 | Registered output pixel |
| out_vld | output | 1 | out_code is new this cycle |

## Verification
A line start can fall in the same cycle as a pixel strobe. In that cycle the block must both restart its counters and emit the first value of the new line. The bench provokes this in the middle of a stripe band and in the middle of a ramp, and also issues a line start with no strobe. A scoreboard model predicts the value of every pixel from the requirements alone. A second collision, a ramp wrap on the last step, is reached by running full lines with step 2 and step 16. The scoreboard judges each case pixel by pixel.

// File: rtl/tpat_pkg.sv
package tpat_pkg;
    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2,
        ST_RAMP = 2'd3
    } tp_state_e;
endpackage

// File: rtl/tpat_fsm.sv
module tpat_fsm
    import tpat_pkg::*;
#(
    parameter int IVL_W    = 2,
    parameter int BAND_LOG = 3,
    localparam int CNT_W   = BAND_LOG + (1 << IVL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_stb,
    input  logic             line_start,
    input  logic             en_i,
    input  logic             sel_i,
    input  logic [IVL_W-1:0] ivl_i,
    output tp_state_e        cur_state,
    output logic [IVL_W-1:0] cur_ivl
);
    tp_state_e        state_q, state_d, start_state;
    logic [CNT_W-1:0] cnt_q, cnt_d, cur_cnt;
    logic [IVL_W-1:0] ivl_q;
    logic             band_end;

    function automatic logic [CNT_W-1:0] band_last(input logic [IVL_W-1:0] iv);
        band_last = CNT_W'((1 << (BAND_LOG + int'(iv))) - 1);
    endfunction

    // Settings of the line in progress, or fresh ones on a line start.
    always_comb begin
        if (!en_i)      start_state = ST_PASS;
        else if (sel_i) start_state = ST_HI;
        else            start_state = ST_RAMP;
        cur_state = line_start ? start_state : state_q;
        cur_ivl   = line_start ? ivl_i : ivl_q;
        cur_cnt   = line_start ? '0 : cnt_q;
        band_end  = (cur_cnt == band_last(cur_ivl));
    end

    // Next-state logic.
    always_comb begin
        state_d = cur_state;
        cnt_d   = cur_cnt;
        unique case (cur_state)
            ST_PASS, ST_RAMP: cnt_d = '0;
            ST_HI: if (pix_stb) begin
                if (band_end) begin
                    state_d = ST_LO;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cur_cnt + 1'b1;
                end
            end
            ST_LO: if (pix_stb) begin
                if (band_end) begin
                    state_d = ST_HI;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cur_cnt + 1'b1;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
            ivl_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ivl_q   <= cur_ivl;
        end
    end

    a_r2_ivl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(ivl_q));
    a_r5_band_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI || state_q == ST_LO) |-> cnt_q <= band_last(ivl_q));
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI && !line_start && !pix_stb) |=> (state_q == ST_HI && $stable(cnt_q)));
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && en_i && sel_i && !pix_stb) |=> (state_q == ST_HI && cnt_q == '0));
endmodule

// File: rtl/tpat_ramp.sv
module tpat_ramp #(
    parameter int CODE_W   = 12,
    parameter int IVL_W    = 2,
    parameter int STEP_LOG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic              line_start,
    input  logic              active,
    input  logic [IVL_W-1:0]  ivl,
    output logic [CODE_W-1:0] cur_val
);
    localparam logic [CODE_W:0] MAXV = (CODE_W+1)'((1 << CODE_W) - 1);
    localparam logic [CODE_W-1:0] FIRST = CODE_W'(1);

    logic [CODE_W-1:0] val_q, val_d;
    logic [CODE_W:0]   step_v, sum_v;

    always_comb begin
        cur_val = line_start ? FIRST : val_q;
        step_v  = (CODE_W+1)'(1) << (STEP_LOG + int'(ivl));
        sum_v   = {1'b0, cur_val} + step_v;
        val_d   = cur_val;
        if (pix_stb && active)
            val_d = (sum_v > MAXV) ? FIRST : sum_v[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= FIRST;
        else        val_q <= val_d;
    end

    a_r6_odd_value: assert property (@(posedge clk) disable iff (!rst_n)
        val_q[0] == 1'b1);
    a_r8_line_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !pix_stb) |=> val_q == FIRST);
endmodule

// File: rtl/tpat_level.sv
module tpat_level #(
    parameter int CODE_W = 12,
    parameter int BLK_W  = 8,
    parameter int HI_OFS = 128
) (
    input  logic [BLK_W-1:0]  blk,
    output logic [CODE_W-1:0] lvl_lo,
    output logic [CODE_W-1:0] lvl_hi
);
    localparam logic [CODE_W:0] MAXV = (CODE_W+1)'((1 << CODE_W) - 1);
    logic [CODE_W:0] hi_sum;

    always_comb begin
        lvl_lo = CODE_W'({blk, 1'b0});
        hi_sum = {1'b0, lvl_lo} + (CODE_W+1)'(HI_OFS);
        lvl_hi = (hi_sum > MAXV) ? MAXV[CODE_W-1:0] : hi_sum[CODE_W-1:0];
    end

    always_comb begin
        a_r5_hi_above: assert (lvl_hi >= lvl_lo);
    end
endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
    import tpat_pkg::*;
#(
    parameter int CODE_W   = 12,
    parameter int BLK_W    = 8,
    parameter int IVL_W    = 2,
    parameter int BAND_LOG = 3,
    parameter int STEP_LOG = 1,
    parameter int HI_OFS   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic              line_start,
    input  logic              tm_en,
    input  logic              pat_sel,
    input  logic [IVL_W-1:0]  pat_ivl,
    input  logic [BLK_W-1:0]  blk_code,
    input  logic [CODE_W-1:0] pix_in,
    output logic [CODE_W-1:0] out_code,
    output logic              out_vld
);
    tp_state_e         cur_state;
    logic [IVL_W-1:0]  cur_ivl;
    logic [BLK_W-1:0]  blk_q, cur_blk;
    logic [CODE_W-1:0] ramp_val, lvl_lo, lvl_hi, sel_code;

    tpat_fsm #(.IVL_W(IVL_W), .BAND_LOG(BAND_LOG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_start(line_start),
        .en_i(tm_en), .sel_i(pat_sel), .ivl_i(pat_ivl),
        .cur_state(cur_state), .cur_ivl(cur_ivl)
    );

    tpat_ramp #(.CODE_W(CODE_W), .IVL_W(IVL_W), .STEP_LOG(STEP_LOG)) u_ramp (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_start(line_start),
        .active(cur_state == ST_RAMP), .ivl(cur_ivl), .cur_val(ramp_val)
    );

    tpat_level #(.CODE_W(CODE_W), .BLK_W(BLK_W), .HI_OFS(HI_OFS)) u_level (
        .blk(cur_blk), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi)
    );

    assign cur_blk = line_start ? blk_code : blk_q;

    // Output selection by state.
    always_comb begin
        unique case (cur_state)
            ST_PASS: sel_code = pix_in;
            ST_HI:   sel_code = lvl_hi;
            ST_LO:   sel_code = lvl_lo;
            ST_RAMP: sel_code = ramp_val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q    <= '0;
            out_code <= '0;
            out_vld  <= 1'b0;
        end else begin
            blk_q   <= cur_blk;
            out_vld <= pix_stb;
            if (pix_stb) out_code <= sel_code;
        end
    end

    a_r3_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> out_vld);
    a_r3_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_stb |=> (!out_vld && $stable(out_code)));
    a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && cur_state == ST_PASS) |=> out_code == $past(pix_in));
    a_r9_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && cur_state == ST_RAMP) |=> out_code[0] == 1'b1);
endmodule

// File: tb/tpat_gen_test.sv
module tpat_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_stb = 1'b0, line_start = 1'b0;
    logic        tm_en = 1'b0, pat_sel = 1'b0;
    logic [1:0]  pat_ivl = 2'd0;
    logic [7:0]  blk_code = 8'd0;
    logic [11:0] pix_in = 12'd0;
    logic [11:0] out_code;
    logic        out_vld;

    always #5 clk = ~clk;

    tpat_gen uut (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_start(line_start),
        .tm_en(tm_en), .pat_sel(pat_sel), .pat_ivl(pat_ivl), .blk_code(blk_code),
        .pix_in(pix_in), .out_code(out_code), .out_vld(out_vld)
    );

    typedef struct { int stamp; logic [11:0] val; string tag; } exp_t;
    exp_t q[$];
    int  cyc = 0;
    int  total = 0, bad = 0;
    bit  finished = 0;

    // Reference model state.
    bit       m_en = 0, m_sel = 0, m_hi = 1;
    int       m_ivl = 0, m_blk = 0, m_cnt = 0, m_ramp = 1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input bit stb, input bit ls, input logic [11:0] din, input string tag);
        int e;
        @(negedge clk);
        pix_stb = stb; line_start = ls; pix_in = din;
        if (ls) begin
            m_en = tm_en; m_sel = pat_sel; m_ivl = int'(pat_ivl); m_blk = int'(blk_code);
            m_cnt = 0; m_hi = 1; m_ramp = 1;
        end
        if (stb) begin
            if (!m_en) e = int'(din);
            else if (m_sel) begin
                e = m_hi ? 2*m_blk + 128 : 2*m_blk;
                if (e > 4095) e = 4095;
                m_cnt++;
                if (m_cnt == (8 << m_ivl)) begin m_cnt = 0; m_hi = !m_hi; end
            end else begin
                e = m_ramp;
                m_ramp = m_ramp + (2 << m_ivl);
                if (m_ramp > 4095) m_ramp = 1;
            end
            q.push_back('{cyc, 12'(e), tag});
        end
    endtask

    task automatic cfg(input bit en, input bit sel, input logic [1:0] iv, input logic [7:0] blk);
        tm_en = en; pat_sel = sel; pat_ivl = iv; blk_code = blk;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 12'((i * 373 + 91) & 12'hfff), tag);
    endtask

    // Monitor: pop the due expectation, or demand an idle output.
    always @(negedge clk) begin
        if (!finished && rst_n) begin
            total++;
            if (q.size() > 0 && q[0].stamp == cyc - 1) begin
                if (!out_vld || out_code !== q[0].val) begin
                    bad++;
                    $display("FAIL %s: actual vld=%0b code=%0d expected vld=1 code=%0d",
                             q[0].tag, out_vld, out_code, q[0].val);
                end
                void'(q.pop_front());
            end else if (out_vld) begin
                bad++;
                $display("FAIL R3: actual vld=1 code=%0d expected vld=0", out_code);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R3: watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_vld !== 1'b0 || out_code !== 12'd0) begin
            bad++;
            $display("FAIL R1: actual vld=%0b code=%0d expected vld=0 code=0", out_vld, out_code);
        end
        rst_n = 1'b1;

        // R1: enable set but no line start yet -> pass-through.
        cfg(1, 1, 2'd0, 8'h50);
        run(4, "R1");
        // R4 with gaps (R3).
        cfg(0, 0, 2'd0, 8'h50);
        step(1, 1, 12'h123, "R4");
        step(0, 0, 12'h0, "R3");
        step(1, 0, 12'hfff, "R4");
        step(0, 0, 12'h0, "R3");
        step(0, 0, 12'h0, "R3");
        run(5, "R4");
        // R6 + R9 ramp with step 2 while pix_in varies.
        cfg(1, 0, 2'd0, 8'h50);
        step(1, 1, 12'habc, "R6");
        run(12, "R9");
        // R2: mid-line changes ignored.
        cfg(0, 1, 2'd3, 8'h10);
        run(6, "R2");
        cfg(1, 0, 2'd1, 8'h50);
        step(1, 1, 12'h0, "R6");
        run(10, "R6");
        cfg(1, 0, 2'd2, 8'h50);
        step(1, 1, 12'h0, "R6");
        run(10, "R6");
        // R7: wrap with step 16 and exact 4095 with step 2.
        cfg(1, 0, 2'd3, 8'h50);
        step(1, 1, 12'h0, "R7");
        run(300, "R7");
        cfg(1, 0, 2'd0, 8'h50);
        step(1, 1, 12'h0, "R7");
        run(2060, "R7");
        // R5 stripes, all widths, several black codes.
        for (int iv = 0; iv < 4; iv++) begin
            cfg(1, 1, 2'(iv), 8'h50);
            step(1, 1, 12'h0, "R5");
            run((8 << iv) * 3 + 3, "R5");
        end
        cfg(1, 1, 2'd0, 8'hff);
        step(1, 1, 12'h0, "R5");
        for (int i = 0; i < 20; i++) begin
            step(1, 0, 12'h0, "R5");
            step(0, 0, 12'h0, "R3");
        end
        cfg(1, 1, 2'd1, 8'h00);
        step(1, 1, 12'h0, "R5");
        run(40, "R5");
        // R8: line start coincident with strobe mid-band, and alone.
        cfg(1, 1, 2'd1, 8'h20);
        step(1, 1, 12'h0, "R8");
        run(21, "R8");
        step(1, 1, 12'h0, "R8");
        run(20, "R8");
        step(0, 1, 12'h0, "R8");
        run(20, "R8");
        cfg(1, 0, 2'd1, 8'h20);
        step(1, 1, 12'h0, "R8");
        run(5, "R8");
        step(1, 1, 12'h0, "R8");
        run(5, "R8");
        step(0, 1, 12'h0, "R8");
        run(5, "R8");
        // Back to pass-through at line start.
        cfg(0, 1, 2'd0, 8'h50);
        step(1, 1, 12'h5a5, "R4");
        run(5, "R4");
        for (int i = 0; i < 4; i++) step(0, 0, 12'h0, "R3");
        @(negedge clk);
        finished = 1;
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R3: actual pending=%0d expected pending=0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule